// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block computes the sixteen syndromes of a (255,239) Reed-Solomon codeword over GF(256) while the codeword arrives one byte per clock. A start input marks the first byte of each block. The block counts 255 bytes from there and then shows the sixteen 8-bit syndromes side by side, with a one-cycle valid strobe and a flag that tells whether any syndrome is nonzero. A downstream error-locator stage uses the results. An all-clear flag means the block went through untouched.

Blocks may follow each other with no idle cycle between them, or they may have idle gaps of any length. The result of one block stays on the outputs while the next block is being accumulated. The results change only when that next block completes. Bytes that arrive outside a counted block window are dropped.

Top module: `rs_syndrome_calc`

## Requirements
- R1: Syndrome S_i equals the XOR over byte positions j = 0..254 of r_j * alpha^(i*(254-j)), for i = 0..15. Here r_0 is the byte sampled with the start input, so the first byte is the highest-order coefficient. alpha is a root of x^8+x^4+x^3+x^2+1 (0x11D).
- R2: A byte sampled with `sof` high begins a new block whatever the earlier accumulator contents were.
- R3: `syn_valid` is high for exactly one cycle. That cycle is the one right after the edge that sampled the 255th byte of a block, counting the start byte as byte 1.
- R4: `syn_flat` and `syn_nonzero` keep their values in every cycle where `syn_valid` is low.
- R5: `syn_nonzero` is 1 exactly when at least one of the sixteen held syndromes is nonzero. Any valid codeword gives 0.
- R6: Blocks sent back to back, with the next `sof` in the cycle after the previous block's last byte, each produce their own correct result with no lost block.
- R7: Idle gaps of any length between blocks are allowed. A byte sampled with `sof` low after a block's 255th byte produces no valid strobe and changes no output.
- R8: While `rst` is high, and after it is released, the outputs are `syn_valid` = 0, `syn_nonzero` = 0 and all syndromes 0, until the first block completes.
- R9: Syndrome S_i sits in bits [8i+7:8i] of `syn_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset, held at least 3 clocks |
| sof | input | 1 | High with the first byte of a block only |
| din | input | 8 | Received byte, highest-order coefficient first |
| syn_valid | output | 1 | One-cycle strobe: new syndromes present |
| syn_nonzero | output | 1 | Some held syndrome is nonzero |
| syn_flat | output | 128 | Sixteen held syndromes, S_i at bits [8i+7:8i] |

## Verification
The assertions assume that a block is sent as 255 bytes on consecutive cycles with no stall inside it, and that start pulses are at least 255 clocks apart. The timing assertion counts from the latest `sof`, so these assumptions are needed for it to hold. The stimulus keeps to them: each block is driven as 255 consecutive bytes, and the next `sof` comes either in the cycle right after the last byte or after an idle gap. Random garbage bytes with `sof` low are placed only inside those gaps.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int GF_W = 8;
  typedef logic [GF_W-1:0] gf_t;

  // multiply by x, reduced by the low part of the field polynomial
  function automatic gf_t gf_xtime(gf_t x, gf_t poly_lo);
    gf_t sh;
    sh = gf_t'({x[GF_W-2:0], 1'b0});
    return x[GF_W-1] ? (sh ^ poly_lo) : sh;
  endfunction

  // shift-and-add field multiply; one constant operand folds into XOR trees
  function automatic gf_t gf_mul(gf_t a, gf_t b, gf_t poly_lo);
    gf_t p;
    gf_t x;
    p = '0;
    x = a;
    for (int k = 0; k < GF_W; k++) begin
      if (b[k]) p = p ^ x;
      x = gf_xtime(x, poly_lo);
    end
    return p;
  endfunction

  function automatic gf_t gf_alpha_pow(int e, gf_t poly_lo);
    gf_t x;
    x = gf_t'(1);
    for (int k = 0; k < e; k++) x = gf_xtime(x, poly_lo);
    return x;
  endfunction
endpackage

// File: rtl/rs_syn_framer.sv
module rs_syn_framer #(
  parameter int N_SYMS = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  output logic accept,
  output logic first,
  output logic last
);
  localparam int CNT_W = $clog2(N_SYMS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SYMS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign first  = sof;
  assign accept = sof | active_q;
  assign last   = sof ? (N_SYMS == 1) : (active_q && (cnt_q == LAST_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (sof) begin
      cnt_q    <= CNT_W'(1);
      active_q <= (N_SYMS > 1);
    end else if (active_q) begin
      if (cnt_q == LAST_IDX) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter gf_t POLY_LO  = 8'h1D,
  parameter int  ROOT_IDX = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic first,
  input  logic last,
  input  gf_t  din,
  output gf_t  nxt,
  output gf_t  syn_q
);
  localparam gf_t ROOT = gf_alpha_pow(ROOT_IDX, POLY_LO);

  gf_t acc_q;
  gf_t scaled;

  generate
    if (ROOT_IDX == 0) begin : g_unity
      assign scaled = acc_q;
    end else begin : g_const_mul
      assign scaled = gf_mul(acc_q, ROOT, POLY_LO);
    end
  endgenerate

  // Horner step; the start byte discards the running value
  assign nxt = first ? din : (scaled ^ din);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      syn_q <= '0;
    end else begin
      if (accept) acc_q <= nxt;
      if (last)   syn_q <= nxt;
    end
  end
endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int  N_SYMS  = 255,
  parameter int  N_ROOTS = 16,
  parameter gf_t POLY_LO = 8'h1D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sof,
  input  logic [GF_W-1:0]         din,
  output logic                    syn_valid,
  output logic                    syn_nonzero,
  output logic [N_ROOTS*GF_W-1:0] syn_flat
);
  localparam int FLAT_W = N_ROOTS * GF_W;

  logic              accept;
  logic              first;
  logic              last;
  logic [FLAT_W-1:0] nxt_all;

  rs_syn_framer #(.N_SYMS(N_SYMS)) u_framer (
    .clk    (clk),
    .rst    (rst),
    .sof    (sof),
    .accept (accept),
    .first  (first),
    .last   (last)
  );

  for (genvar r = 0; r < N_ROOTS; r++) begin : g_root
    rs_syn_cell #(.POLY_LO(POLY_LO), .ROOT_IDX(r)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .first  (first),
      .last   (last),
      .din    (din),
      .nxt    (nxt_all[r*GF_W +: GF_W]),
      .syn_q  (syn_flat[r*GF_W +: GF_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_valid   <= 1'b0;
      syn_nonzero <= 1'b0;
    end else begin
      syn_valid <= last;
      if (last) syn_nonzero <= |nxt_all;
    end
  end
endmodule

// File: rtl/rs_syn_chk.sv
module rs_syn_chk #(
  parameter int N_SYMS  = 255,
  parameter int N_ROOTS = 16,
  parameter int SYM_W   = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sof,
  input logic                     syn_valid,
  input logic                     syn_nonzero,
  input logic [N_ROOTS*SYM_W-1:0] syn_flat
);
  localparam int CW = $clog2(N_SYMS + 2);

  logic [CW-1:0] since_sof;

  always_ff @(posedge clk) begin
    if (rst) since_sof <= '0;
    else if (sof) since_sof <= CW'(1);
    else if (since_sof != '0 && since_sof <= CW'(N_SYMS)) since_sof <= since_sof + 1'b1;
  end

  assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    syn_valid |=> !syn_valid);

  assert_timing_R3: assert property (@(posedge clk) disable iff (rst)
    syn_valid |-> (since_sof == CW'(N_SYMS)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !syn_valid |-> ($stable(syn_flat) && $stable(syn_nonzero)));

  assert_flag_R5: assert property (@(posedge clk) disable iff (rst)
    syn_nonzero == (syn_flat != '0));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!syn_valid && !syn_nonzero && syn_flat == '0));
endmodule

bind rs_syndrome_calc rs_syn_chk #(
  .N_SYMS  (N_SYMS),
  .N_ROOTS (N_ROOTS),
  .SYM_W   (rs_syn_pkg::GF_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sof         (sof),
  .syn_valid   (syn_valid),
  .syn_nonzero (syn_nonzero),
  .syn_flat    (syn_flat)
);

// File: tb/sim_rs_syndrome_calc.sv
module sim_rs_syndrome_calc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sof = 1'b0;
  logic [7:0]   din = 8'h00;
  logic         syn_valid;
  logic         syn_nonzero;
  logic [127:0] syn_flat;

  always #4 clk = ~clk;

  rs_syndrome_calc u0 (
    .clk(clk), .rst(rst), .sof(sof), .din(din),
    .syn_valid(syn_valid), .syn_nonzero(syn_nonzero), .syn_flat(syn_flat)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit started = 0;

  logic [7:0] exp_t [0:254];
  int         log_t [0:255];
  logic [7:0] gpoly [0:16];
  logic [7:0] blk   [0:254];

  logic [127:0] exp_q [$];
  bit           nz_q  [$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return exp_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  function automatic logic [127:0] calc_syn();
    logic [127:0] v;
    logic [7:0]   s;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      s = 8'h00;
      for (int j = 0; j < 255; j++)
        if (blk[j] != 0) s = s ^ exp_t[(log_t[blk[j]] + i * (254 - j)) % 255];
      v[i*8 +: 8] = s;
    end
    return v;
  endfunction

  task automatic fill_code(input int shift);
    for (int j = 0; j < 255; j++) begin
      int e;
      e = 254 - j - shift;
      blk[j] = (e >= 0 && e <= 16) ? gpoly[e] : 8'h00;
    end
  endtask

  task automatic send_block();
    logic [127:0] v;
    v = calc_syn();
    exp_q.push_back(v);
    nz_q.push_back(v != '0);
    for (int j = 0; j < 255; j++) begin
      @(negedge clk);
      sof = (j == 0);
      din = blk[j];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sof = 1'b0;
      din = 8'($urandom);
    end
  endtask

  // bench-side count of edges since the sampled start byte
  int since_sof = 0;
  always @(posedge clk) begin
    if (rst) since_sof <= 0;
    else if (sof) since_sof <= 1;
    else if (since_sof != 0 && since_sof < 300) since_sof <= since_sof + 1;
  end

  bit           prev_valid = 0;
  int           since_valid = 0;
  logic [127:0] hold_ref = '0;
  bit           hold_nz = 0;

  always @(negedge clk) begin
    if (started && !rst) begin
      if (syn_valid || since_sof == 255)
        chk(syn_valid && since_sof == 255, "R3 strobe timing", 128'(syn_valid), 128'(since_sof));
      if (syn_valid) begin
        chk(!prev_valid, "R3 single-cycle strobe", 128'(prev_valid), 128'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 spurious strobe", 128'(syn_valid), 128'd0);
        end else begin
          logic [127:0] e;
          bit ez;
          e  = exp_q.pop_front();
          ez = nz_q.pop_front();
          chk(syn_flat == e, "R1 R2 R9 syndromes", syn_flat, e);
          chk(syn_nonzero == ez, "R5 nonzero flag", 128'(syn_nonzero), 128'(ez));
        end
        hold_ref    = syn_flat;
        hold_nz     = syn_nonzero;
        since_valid = 0;
      end else begin
        since_valid++;
        if (since_valid == 100) begin
          chk(syn_flat == hold_ref, "R4 hold syndromes", syn_flat, hold_ref);
          chk(syn_nonzero == hold_nz, "R4 hold flag", 128'(syn_nonzero), 128'(hold_nz));
        end
      end
      prev_valid = syn_valid;
    end
  end

  initial begin
    logic [7:0] x;
    x = 8'h01;
    for (int k = 0; k < 255; k++) begin
      exp_t[k] = x;
      log_t[x] = k;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    log_t[0] = 0;
    for (int k = 0; k <= 16; k++) gpoly[k] = 8'h00;
    gpoly[0] = 8'h01;
    for (int i = 0; i < 16; i++) begin
      for (int k = 16; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ fmul(gpoly[k], exp_t[i]);
      gpoly[0] = fmul(gpoly[0], exp_t[i]);
    end

    // R8: reset state
    repeat (4) @(negedge clk);
    chk(!syn_valid && !syn_nonzero && syn_flat == '0, "R8 during reset", syn_flat, '0);
    rst = 1'b0;
    started = 1;
    @(negedge clk);
    chk(!syn_valid && !syn_nonzero && syn_flat == '0, "R8 after release", syn_flat, '0);

    // R5: all-zero block
    for (int j = 0; j < 255; j++) blk[j] = 8'h00;
    send_block();

    // R5 R6: shifted generator codewords back to back
    fill_code(0);   send_block();
    fill_code(100); send_block();
    fill_code(238); send_block();

    // R1 R2: random blocks back to back
    for (int b = 0; b < 3; b++) begin
      for (int j = 0; j < 255; j++) blk[j] = 8'($urandom);
      send_block();
    end

    // R7: gaps carrying garbage bytes
    idle(1);
    for (int j = 0; j < 255; j++) blk[j] = 8'($urandom);
    send_block();
    idle(7);
    for (int j = 0; j < 255; j++) blk[j] = 8'($urandom);
    send_block();
    idle(300);

    // R1 R9: single error at every position on a codeword, back to back
    for (int p = 0; p < 255; p++) begin
      fill_code(0);
      blk[p] = blk[p] ^ 8'(p + 1);
      send_block();
    end
    idle(300);

    chk(exp_q.size() == 0, "R6 all blocks reported", 128'(exp_q.size()), 128'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule